// File: doc/BRIEF.md
# Circular-buffer capture sequencer

This block sequences the writing of probe samples into an external circular sample memory for an on-chip logic analyzer. It produces the memory's write strobe and write address, plus a read pointer that marks where the oldest sample of a finished capture sits. A trigger signal is computed elsewhere and arrives as a single bit. The capture is set up through a few register-style inputs: a capture mode, a trigger position, a start request and a stop request. The current sequencer state is visible on an output, so a host-side reader can tell when the buffer holds a complete record.

There are three capture modes. In trigger-centred mode the sequencer first records a programmable number of pre-trigger samples. It then keeps overwriting the ring until the trigger fires, and after that it records the remaining slots. The finished buffer therefore holds history from both sides of the event. Immediate mode fills the whole buffer at once and takes no notice of the trigger. Step mode records one sample on each cycle in which the trigger is high, so the trigger acts as a sampling enable.

Top module: `lac_capture_ctrl`

## Requirements
- R1: After reset, the write strobe is 0, both pointers are 0 and the state output is idle (state code 0).
- R2: The write strobe is low while idle. Once a start request is taken in idle with a mode of 0 or 1, the write strobe is high in the following cycle and the first sample goes to address 0. Mode codes are: 0 trigger-centred, 1 immediate, 2 step, 3 reserved.
- R3: In trigger-centred mode with trigger position L > 0, the sequencer spends L cycles in the pre-fill state (code 1). During those cycles the write pointer steps 0, 1, ..., L-1, the read pointer stays 0, and the trigger is ignored. The sequencer then enters the armed state (code 2) with the write pointer at L. When L = 0 it enters the armed state directly.
- R4: While armed, each cycle without a trigger advances both pointers by one modulo DEPTH, so the read pointer always equals the write pointer minus L modulo DEPTH.
- R5: A trigger seen while armed with the write pointer at W writes that sample and then DEPTH-L-1 more, using the post-trigger state (code 3). It then enters the done state (code 5) with the write pointer at (W+DEPTH-L-1) mod DEPTH, the read pointer at (W-L) mod DEPTH, and (write pointer + 1) mod DEPTH equal to the read pointer. Over the whole capture the strobe is high for DEPTH plus the number of armed cycles without a trigger.
- R6: In trigger-centred mode with the trigger already high at start, exactly DEPTH samples are written and the write pointer ends at DEPTH-1.
- R7: Immediate mode writes DEPTH consecutive samples whatever the trigger does. The read pointer stays 0, and the sequencer ends in the done state with the write pointer at DEPTH-1.
- R8: In step mode (state code 4) the write strobe is high exactly on the cycles where the trigger is high. The write pointer advances only on those cycles. After the DEPTH-th such cycle the state becomes done with the write pointer at DEPTH-1.
- R9: The write strobe is low in the idle and done states.
- R10: A stop request returns the sequencer to idle from any state and clears both pointers on the next cycle. It takes priority over a simultaneous start.
- R11: A start request outside the idle state has no effect. A start in idle with the reserved mode 3 leaves the sequencer idle with the strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Capture mode: 0 trigger-centred, 1 immediate, 2 step, 3 reserved |
| trig_loc_i | input | PTR_W | Number of pre-trigger samples L |
| start_i | input | 1 | Start request, taken only when idle |
| stop_i | input | 1 | Stop request: return to idle and clear pointers |
| trig_i | input | 1 | Trigger condition from the comparators |
| wr_en_o | output | 1 | Sample memory write strobe |
| wr_ptr_o | output | PTR_W | Sample memory write address |
| rd_ptr_o | output | PTR_W | Address of the oldest sample |
| state_o | output | 3 | State: 0 idle, 1 pre-fill, 2 armed, 3 post-trigger, 4 step, 5 done |

## Verification
The bench builds the block with DEPTH = 8, which makes every trigger position reachable. It sweeps all eight positions against several armed-wait lengths, including waits longer than the ring, so the write pointer wraps before the trigger arrives. It also runs a trigger held high from the start. Together these cover the cases where the trigger lands on the last slot (the post-trigger phase is skipped) and where the position is zero (the pre-fill phase is skipped). Immediate and step modes run with several trigger patterns and spacings. Stop and start requests are applied in states where they must or must not take effect.

// File: rtl/lac_pkg.sv
package lac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PREFILL = 3'd1,
      ST_ARMED   = 3'd2,
      ST_POST    = 3'd3,
      ST_STEP    = 3'd4,
      ST_DONE    = 3'd5
   } lac_state_e;

   typedef enum logic [1:0] {
      MODE_CENTRED = 2'd0,
      MODE_IMMED   = 2'd1,
      MODE_STEP    = 2'd2,
      MODE_RSVD    = 2'd3
   } lac_mode_e;

endpackage

// File: rtl/lac_ptr_ctr.sv
module lac_ptr_ctr #(
   parameter int WIDTH = 3
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] cnt_q;

   // Wraps naturally modulo 2**WIDTH (ring depth is a power of two)
   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) cnt_q <= '0;
      else if (inc_i)     cnt_q <= cnt_q + 1'b1;
   end

   assign q_o = cnt_q;

   a_r10_clear_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i |=> (q_o == '0));

endmodule

// File: rtl/lac_seq.sv
module lac_seq
   import lac_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [1:0]    mode_i,
   input  logic [PW-1:0] trig_loc_i,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          trig_i,
   input  logic [PW-1:0] wp_i,
   input  logic [PW-1:0] rd_i,
   output lac_state_e    state_o,
   output logic          wp_clr_o,
   output logic          wp_inc_o,
   output logic          rd_clr_o,
   output logic          rd_inc_o,
   output logic          wr_en_o
);

   localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("lac_seq: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   lac_state_e state_q, state_d;
   logic       prefill_end, ring_closed, loc_is_last;

   assign prefill_end = (wp_i == PW'(trig_loc_i - 1'b1));
   assign ring_closed = (PW'(wp_i + 1'b1) == rd_i);
   assign loc_is_last = (trig_loc_i == LAST_SLOT);

   always_comb begin
      state_d  = state_q;
      wp_clr_o = 1'b0;
      wp_inc_o = 1'b0;
      rd_clr_o = 1'b0;
      rd_inc_o = 1'b0;
      if (stop_i) begin
         state_d  = ST_IDLE;
         wp_clr_o = 1'b1;
         rd_clr_o = 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  wp_clr_o = 1'b1;
                  rd_clr_o = 1'b1;
                  unique case (lac_mode_e'(mode_i))
                     MODE_CENTRED: state_d = (trig_loc_i == '0) ? ST_ARMED : ST_PREFILL;
                     MODE_IMMED:   state_d = ST_POST;
                     MODE_STEP:    state_d = ST_STEP;
                     default:      state_d = ST_IDLE;
                  endcase
               end
            end
            ST_PREFILL: begin
               wp_inc_o = 1'b1;
               if (prefill_end) state_d = ST_ARMED;
            end
            ST_ARMED: begin
               if (trig_i) begin
                  if (loc_is_last) state_d = ST_DONE;
                  else begin
                     state_d  = ST_POST;
                     wp_inc_o = 1'b1;
                  end
               end else begin
                  wp_inc_o = 1'b1;
                  rd_inc_o = 1'b1;
               end
            end
            ST_POST: begin
               if (ring_closed) state_d = ST_DONE;
               else             wp_inc_o = 1'b1;
            end
            ST_STEP: begin
               if (trig_i) begin
                  if (wp_i == LAST_SLOT) state_d = ST_DONE;
                  else                   wp_inc_o = 1'b1;
               end
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= ST_IDLE;
      else       state_q <= state_d;
   end

   assign state_o = state_q;
   assign wr_en_o = (state_q == ST_PREFILL) || (state_q == ST_ARMED) ||
                    (state_q == ST_POST) || ((state_q == ST_STEP) && trig_i);

   a_r3_prefill_step: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_PREFILL && !stop_i) |=> (wp_i == PW'($past(wp_i) + 1'b1)) && (rd_i == '0));

   a_r4_window_follow: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_ARMED && !stop_i && !trig_i) |=>
         (rd_i == PW'($past(rd_i) + 1'b1)) && (wp_i == PW'($past(wp_i) + 1'b1)));

   a_r7_post_rd_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_POST && !stop_i) |=> $stable(rd_i));

   a_r8_step_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_STEP && !stop_i && !trig_i) |=> $stable(wp_i));

   a_r11_done_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_DONE && !stop_i) |=> (state_q == ST_DONE));

endmodule

// File: rtl/lac_capture_ctrl.sv
module lac_capture_ctrl
   import lac_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [1:0]       mode_i,
   input  logic [PTR_W-1:0] trig_loc_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             trig_i,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_ptr_o,
   output logic [PTR_W-1:0] rd_ptr_o,
   output logic [2:0]       state_o
);

   lac_state_e state;
   logic       wp_clr, wp_inc, rd_clr, rd_inc;

   lac_seq #(.DEPTH(DEPTH)) i_seq (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .mode_i    (mode_i),
      .trig_loc_i(trig_loc_i),
      .start_i   (start_i),
      .stop_i    (stop_i),
      .trig_i    (trig_i),
      .wp_i      (wr_ptr_o),
      .rd_i      (rd_ptr_o),
      .state_o   (state),
      .wp_clr_o  (wp_clr),
      .wp_inc_o  (wp_inc),
      .rd_clr_o  (rd_clr),
      .rd_inc_o  (rd_inc),
      .wr_en_o   (wr_en_o)
   );

   lac_ptr_ctr #(.WIDTH(PTR_W)) i_wr_ptr (
      .clk_i(clk_i), .rst_i(rst_i), .clr_i(wp_clr), .inc_i(wp_inc), .q_o(wr_ptr_o)
   );

   lac_ptr_ctr #(.WIDTH(PTR_W)) i_rd_ptr (
      .clk_i(clk_i), .rst_i(rst_i), .clr_i(rd_clr), .inc_i(rd_inc), .q_o(rd_ptr_o)
   );

   assign state_o = state;

   a_r9_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_IDLE || state_o == ST_DONE) |-> !wr_en_o);

   a_r10_stop: assert property (@(posedge clk_i) disable iff (rst_i)
      stop_i |=> (state_o == ST_IDLE) && (wr_ptr_o == '0) && (rd_ptr_o == '0));

   a_r2_wen_after_start: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_IDLE && start_i && !stop_i && mode_i == MODE_IMMED) |=>
         wr_en_o && (wr_ptr_o == '0));

   a_r5_done_closed: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_DONE && ($past(state_o) == ST_POST || $past(state_o) == ST_ARMED)) |->
         (PTR_W'(wr_ptr_o + 1'b1) == rd_ptr_o));

endmodule

// File: tb/test_lac_capture_ctrl.sv
module test_lac_capture_ctrl;

   localparam int D  = 8;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    mode = 2'd0;
   logic [PW-1:0] loc = '0;
   logic          start = 1'b0, stop = 1'b0, trig = 1'b0;
   logic          wr_en;
   logic [PW-1:0] wp, rd;
   logic [2:0]    state;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   lac_capture_ctrl #(.DEPTH(D)) i_lac_capture_ctrl (
      .clk_i(clk), .rst_i(rst), .mode_i(mode), .trig_loc_i(loc),
      .start_i(start), .stop_i(stop), .trig_i(trig),
      .wr_en_o(wr_en), .wr_ptr_o(wp), .rd_ptr_o(rd), .state_o(state)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_stop();
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   // Trigger-centred run: L = tl, trigger after dly armed cycles (or held from start)
   task automatic run_centred(input int tl, input int dly, input bit hold);
      int k = 0, writes = 0, bad_pre = 0, bad_win = 0;
      bit fired = hold;
      int ewp, erd;
      do_stop();
      mode = 2'd0; loc = PW'(tl); trig = hold; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(wr_en == 1'b1, "R2 strobe after start", int'(wr_en), 1);
      while (state != 3'd5 && k < 64) begin
         if (wr_en) writes++;
         if (k < tl) begin
            if (state != 3'd1 || wp != PW'(k) || rd != '0) bad_pre++;
         end else if (state == 3'd2) begin
            if (rd != PW'(int'(wp) - tl)) bad_win++;
         end
         if (!fired && k == tl + dly) begin
            trig = 1'b1; fired = 1'b1;
         end else if (!hold) trig = 1'b0;
         @(negedge clk);
         k++;
      end
      trig = 1'b0;
      ewp = (dly + D - 1) % D;
      erd = dly % D;
      chk(bad_pre == 0, "R3 prefill pointers", bad_pre, 0);
      chk(bad_win == 0, "R4 armed window", bad_win, 0);
      chk(state == 3'd5, "R5 done state", int'(state), 5);
      chk(wr_en == 1'b0, "R9 strobe low when done", int'(wr_en), 0);
      chk(writes == D + dly, hold ? "R6 sample count" : "R5 sample count", writes, D + dly);
      chk(int'(wp) == ewp, hold ? "R6 final write ptr" : "R5 final write ptr", int'(wp), ewp);
      chk(int'(rd) == erd, "R5 final read ptr", int'(rd), erd);
      chk(PW'(wp + 1'b1) == rd, "R5 ring closed", int'(PW'(wp + 1'b1)), int'(rd));
   endtask

   task automatic run_immediate(input int pat);
      int k = 0, writes = 0, bad = 0;
      do_stop();
      mode = 2'd1; trig = pat[0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (state != 3'd5 && k < 64) begin
         if (wr_en) writes++;
         if (rd != '0) bad++;
         trig = ((k >> pat) & 1) != 0;
         @(negedge clk);
         k++;
      end
      trig = 1'b0;
      chk(state == 3'd5, "R7 done state", int'(state), 5);
      chk(writes == D, "R7 sample count", writes, D);
      chk(wp == PW'(D - 1), "R7 final write ptr", int'(wp), D - 1);
      chk(bad == 0 && rd == '0, "R7 read ptr stays 0", bad, 0);
   endtask

   task automatic run_step(input int gap);
      int k = 0, n = 0, bad = 0;
      do_stop();
      mode = 2'd2; trig = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (state != 3'd5 && k < 400) begin
         trig = (k % gap) == (gap - 1);
         #1;
         if (trig) begin
            if (!wr_en || wp != PW'(n)) bad++;
            n++;
         end else if (wr_en) bad++;
         @(negedge clk);
         k++;
      end
      trig = 1'b0;
      chk(bad == 0, "R8 strobe follows trigger", bad, 0);
      chk(n == D, "R8 trigger cycles to done", n, D);
      chk(state == 3'd5, "R8 done state", int'(state), 5);
      chk(wp == PW'(D - 1), "R8 final write ptr", int'(wp), D - 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk(state == 3'd0, "R1 idle after reset", int'(state), 0);
      chk(wp == '0 && rd == '0, "R1 pointers after reset", int'(wp) + int'(rd), 0);
      chk(wr_en == 1'b0, "R1 strobe after reset", int'(wr_en), 0);
      @(negedge clk);
      chk(wr_en == 1'b0, "R2 strobe low before start", int'(wr_en), 0);

      for (int tl = 0; tl < D; tl++) begin
         run_centred(tl, 0, 1'b0);
         run_centred(tl, 3, 1'b0);
         run_centred(tl, 11, 1'b0);
         run_centred(tl, 0, 1'b1);
      end

      for (int p = 0; p < 3; p++) run_immediate(p);

      // R11: start while done has no effect
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(state == 3'd5, "R11 start ignored when done", int'(state), 5);
      chk(wp == PW'(D - 1), "R11 pointer unchanged", int'(wp), D - 1);

      for (int g = 1; g <= 4; g++) run_step(g);

      // R11: reserved mode
      do_stop();
      mode = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(state == 3'd0, "R11 reserved mode stays idle", int'(state), 0);
      chk(wr_en == 1'b0, "R11 reserved mode strobe", int'(wr_en), 0);

      // R10: stop mid-capture with simultaneous start
      mode = 2'd0; loc = 3'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      chk(state == 3'd2, "R10 armed before stop", int'(state), 2);
      stop = 1'b1; start = 1'b1;
      @(negedge clk);
      stop = 1'b0; start = 1'b0;
      chk(state == 3'd0, "R10 idle after stop", int'(state), 0);
      chk(wp == '0 && rd == '0, "R10 pointers cleared", int'(wp) + int'(rd), 0);
      chk(wr_en == 1'b0, "R10 strobe low after stop", int'(wr_en), 0);

      // R10: stop from step mode
      mode = 2'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0; trig = 1'b1;
      repeat (3) @(negedge clk);
      trig = 1'b0;
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk(state == 3'd0 && wp == '0, "R10 stop from step", int'(wp), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule